// File: doc/BRIEF.md
# Four-Phase Multiplexed Read Link

This block models a read transaction that crosses a link with no shared clock between a requesting device and a responding memory. One set of lines carries first the address and then the returned data. Three control wires pace the exchange: a read request raised by the requester, an acknowledge that both sides raise in turn, and a data-ready strobe raised by the responder. Each side is a clocked state machine. It sees the other side's control wires only through a two-flop synchronizer. Bus ownership is modelled with per-side drive enables instead of tri-state pins.

A user issues a one-cycle `start` with an address. The requester places the address on the lines and runs the address phase. The responder captures the address and waits a programmable number of cycles. It then reads a local word array, whose contents are a fixed function of the address, and runs the data phase. The requester captures the word and finishes the handshake. It then pulses `done` and shows the word on `rdata`. The control wires, the shared lines and both drive enables are brought out so that the protocol can be observed.

Top module: `mplex_read_link`

## Requirements
- R1: While reset is asserted and just after it: read request, acknowledge, data-ready, both drive enables, `busy` and `done` are 0, and the shared lines read 0.
- R2: A `start` accepted while idle raises `busy` and the read request, with the zero-extended address on the shared lines, in the cycle after the clock edge that sampled `start`.
- R3: Every transaction produces exactly this sequence of single wire transitions, one per cycle at most: request rises, acknowledge rises, request falls, acknowledge falls, data-ready rises, acknowledge rises, data-ready falls, acknowledge falls.
- R4: Only the requester drives the lines while the request is high, and the lines hold the requested address for that whole time.
- R5: Only the responder drives the lines while data-ready is high, and the lines hold the memory word for that whole time.
- R6: `rdata` takes the word `((a * 0x9E37) ^ 0x5A5A) mod 2^16` for address `a` in the cycle `done` is high. It holds that value until the next `done`.
- R7: With latency setting L (0 to 15), data-ready rises exactly max(L,2)+1 cycles after the acknowledge of the address phase falls.
- R8: At most one drive enable is high in any cycle. When neither is high, the shared lines read 0.
- R9: A `start` pulse arriving while `busy` is high is ignored. It causes no second transaction and no second `done`, and the returned data belongs to the first address.
- R10: `done` is high for exactly one cycle per transaction. `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both state machines |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| addr | input | AW | Address sampled with `start` |
| lat_cfg | input | LW | Responder wait setting, in cycles |
| busy | output | 1 | Requester is inside a transaction |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last word read |
| link_bus | output | DW | Value on the shared address/data lines |
| link_req | output | 1 | Read request wire |
| link_ack | output | 1 | Acknowledge wire (OR of both sides) |
| link_rdy | output | 1 | Data-ready wire |
| req_drive | output | 1 | Requester drives the shared lines |
| rsp_drive | output | 1 | Responder drives the shared lines |

## Verification
A requester stuck in the wrong state shows up within a few cycles. Either the request never falls after the acknowledge, or the acknowledge rises before data-ready, and the edge-order monitor reports it at that transition. A responder that mis-times its wait, or that looks at its own stale acknowledge through the synchronizer, shifts the data-ready rise away from max(L,2)+1 cycles. That error is visible in the first transaction with that latency, with the 0, 1 and 2 settings being the sharpest cases. A wrong captured address or a wrong ownership hand-over changes the value on the shared lines during the data-ready window. It also changes `rdata` at the `done` pulse.

// File: rtl/mrl_pkg.sv
package mrl_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_WAIT_RDY,
    RQ_ACK_DATA,
    RQ_DRAIN
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK_ADDR,
    RS_WAIT,
    RS_DRIVE,
    RS_RELEASE
  } rs_state_t;

  localparam logic [31:0] WORD_MULT = 32'h0000_9E37;
  localparam logic [31:0] WORD_SEED = 32'h0000_5A5A;

  // Content of the responder's word array at a given address.
  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * WORD_MULT) ^ WORD_SEED;
  endfunction

  // Cycles from the address-phase acknowledge falling to data-ready
  // rising: the wait setting, but never less than the synchronizer drain.
  function automatic logic [31:0] rdy_gap(input logic [31:0] lat);
    logic [31:0] base;
    base = (lat > 32'd2) ? lat : 32'd2;
    return base + 32'd1;
  endfunction

endpackage

// File: rtl/mrl_sync2.sv
module mrl_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_in[i];
        stage2 <= stage1;
      end
    end
    assign sync_out[i] = stage2;
  end

endmodule

// File: rtl/mrl_requester.sv
module mrl_requester
  import mrl_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic          ack_s,
  input  logic          rdy_s,
  input  logic [DW-1:0] bus_in,
  output logic          req_o,
  output logic          ack_o,
  output logic          drv_o,
  output logic [DW-1:0] bus_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  rq_state_t     state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cap_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  // named events
  logic launch_ev, addr_acked_ev, data_seen_ev, rdy_gone_ev, finish_ev;
  assign launch_ev     = (state_q == RQ_IDLE) && start;
  assign addr_acked_ev = (state_q == RQ_ADDR) && ack_s;
  assign data_seen_ev  = (state_q == RQ_WAIT_RDY) && rdy_s;
  assign rdy_gone_ev   = (state_q == RQ_ACK_DATA) && !rdy_s;
  assign finish_ev     = (state_q == RQ_DRAIN) && !ack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      addr_q  <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_ev;
      unique case (state_q)
        RQ_IDLE: if (launch_ev) begin
          addr_q  <= addr_in;
          state_q <= RQ_ADDR;
        end
        RQ_ADDR:     if (addr_acked_ev) state_q <= RQ_WAIT_RDY;
        RQ_WAIT_RDY: if (data_seen_ev) begin
          cap_q   <= bus_in;
          state_q <= RQ_ACK_DATA;
        end
        RQ_ACK_DATA: if (rdy_gone_ev) state_q <= RQ_DRAIN;
        RQ_DRAIN:    if (finish_ev) begin
          rdata_q <= cap_q;
          state_q <= RQ_IDLE;
        end
        default: state_q <= RQ_IDLE;
      endcase
    end
  end

  assign req_o   = (state_q == RQ_ADDR);
  assign drv_o   = (state_q == RQ_ADDR);
  assign ack_o   = (state_q == RQ_ACK_DATA);
  assign bus_o   = DW'(addr_q);
  assign busy_o  = (state_q != RQ_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  AST_REQ_FALLS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(ack_s)); // R4
  AST_DATA_ACK_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(rdy_s)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

endmodule

// File: rtl/mrl_responder.sv
module mrl_responder
  import mrl_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lat_cfg,
  input  logic          req_s,
  input  logic          ack_s,
  input  logic [AW-1:0] addr_in,
  output logic          ack_o,
  output logic          rdy_o,
  output logic          drv_o,
  output logic [DW-1:0] bus_o
);

  localparam int DEPTH = 1 << AW;
  localparam int GW    = LW + 1;

  rs_state_t     state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] wait_q;
  logic [LW-1:0] lat_q;
  logic [DW-1:0] word_q;
  logic [GW-1:0] gap_q;
  logic [DW-1:0] mem_q [DEPTH];

  // named events
  logic addr_seen_ev, req_gone_ev, wait_over_ev, data_acked_ev, release_ev;
  assign addr_seen_ev  = (state_q == RS_IDLE) && req_s;
  assign req_gone_ev   = (state_q == RS_ACK_ADDR) && !req_s;
  assign wait_over_ev  = (state_q == RS_WAIT) && (wait_q == '0) && !ack_s;
  assign data_acked_ev = (state_q == RS_DRIVE) && ack_s;
  assign release_ev    = (state_q == RS_RELEASE) && !ack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(word_at(32'(i)));
      state_q <= RS_IDLE;
      addr_q  <= '0;
      wait_q  <= '0;
      lat_q   <= '0;
      word_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        RS_IDLE: if (addr_seen_ev) begin
          addr_q  <= addr_in;
          state_q <= RS_ACK_ADDR;
        end
        RS_ACK_ADDR: if (req_gone_ev) begin
          wait_q  <= lat_cfg;
          lat_q   <= lat_cfg;
          gap_q   <= '0;
          state_q <= RS_WAIT;
        end
        RS_WAIT: begin
          gap_q <= gap_q + 1'b1;
          if (wait_over_ev) begin
            word_q  <= mem_q[addr_q];
            state_q <= RS_DRIVE;
          end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
          end
        end
        RS_DRIVE:   if (data_acked_ev) state_q <= RS_RELEASE;
        RS_RELEASE: if (release_ev) state_q <= RS_IDLE;
        default:    state_q <= RS_IDLE;
      endcase
    end
  end

  assign ack_o = (state_q == RS_ACK_ADDR);
  assign rdy_o = (state_q == RS_DRIVE);
  assign drv_o = (state_q == RS_DRIVE);
  assign bus_o = word_q;

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s)); // R3
  AST_RDY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> (32'(gap_q) == rdy_gap(32'(lat_q)))); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && $past(rdy_o)) |-> $stable(bus_o)); // R5

endmodule

// File: rtl/mplex_read_link.sv
module mplex_read_link #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] lat_cfg,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] link_bus,
  output logic          link_req,
  output logic          link_ack,
  output logic          link_rdy,
  output logic          req_drive,
  output logic          rsp_drive
);

  logic          rq_req, rq_ack, rq_drv;
  logic [DW-1:0] rq_bus;
  logic          rs_ack, rs_rdy, rs_drv;
  logic [DW-1:0] rs_bus;
  logic          ack_w, req_w, rdy_w;
  logic [DW-1:0] bus_w;
  logic [1:0]    rq_sync, rs_sync;

  // wired-OR acknowledge, enable-selected shared lines
  assign ack_w = rq_ack | rs_ack;
  assign req_w = rq_req;
  assign rdy_w = rs_rdy;
  assign bus_w = rq_drv ? rq_bus : (rs_drv ? rs_bus : '0);

  mrl_sync2 #(.W(2)) i_sync_rq (
    .clk(clk), .rst_n(rst_n),
    .async_in({ack_w, rdy_w}), .sync_out(rq_sync)
  );

  mrl_sync2 #(.W(2)) i_sync_rs (
    .clk(clk), .rst_n(rst_n),
    .async_in({req_w, ack_w}), .sync_out(rs_sync)
  );

  mrl_requester #(.AW(AW), .DW(DW)) i_rq (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr),
    .ack_s(rq_sync[1]), .rdy_s(rq_sync[0]), .bus_in(bus_w),
    .req_o(rq_req), .ack_o(rq_ack), .drv_o(rq_drv), .bus_o(rq_bus),
    .busy_o(busy), .done_o(done), .rdata_o(rdata)
  );

  mrl_responder #(.AW(AW), .DW(DW), .LW(LW)) i_rs (
    .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg),
    .req_s(rs_sync[1]), .ack_s(rs_sync[0]), .addr_in(bus_w[AW-1:0]),
    .ack_o(rs_ack), .rdy_o(rs_rdy), .drv_o(rs_drv), .bus_o(rs_bus)
  );

  assign link_bus  = bus_w;
  assign link_req  = req_w;
  assign link_ack  = ack_w;
  assign link_rdy  = rdy_w;
  assign req_drive = rq_drv;
  assign rsp_drive = rs_drv;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_drv && rs_drv)); // R8
  AST_RDY_WITH_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_w) |-> !ack_w); // R3
  AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_ack && rs_ack)); // R3

endmodule

// File: tb/test_mplex_read_link.sv
`timescale 1ns/1ps
module test_mplex_read_link;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] lat_cfg = '0;
  logic          busy, done;
  logic [DW-1:0] rdata, link_bus;
  logic          link_req, link_ack, link_rdy, req_drive, rsp_drive;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int cur_addr = 0;
  int exp_lat  = 0;
  int step = 0;
  int cyc = 0;
  int ackfall_cyc = 0;
  bit p_req = 0, p_ack = 0, p_rdy = 0;
  int exp_seq [8] = '{1, 3, 2, 4, 5, 3, 6, 4};

  always #2 clk = ~clk;

  mplex_read_link #(.AW(AW), .DW(DW), .LW(LW)) i_mplex_read_link (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .lat_cfg(lat_cfg),
    .busy(busy), .done(done), .rdata(rdata), .link_bus(link_bus),
    .link_req(link_req), .link_ack(link_ack), .link_rdy(link_rdy),
    .req_drive(req_drive), .rsp_drive(rsp_drive)
  );

  function automatic logic [15:0] model_word(input int a);
    int p;
    p = (a * 40503) ^ 23130;
    return p[15:0];
  endfunction

  function automatic int model_gap(input int l);
    return ((l < 2) ? 2 : l) + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // protocol monitor: edge order, ownership, line contents, gap
  always @(negedge clk) begin
    int nev, ev;
    cyc++;
    if (rst_n) begin
      nev = 0; ev = 0;
      if (link_req && !p_req) begin nev++; ev = 1; end
      if (!link_req && p_req) begin nev++; ev = 2; end
      if (link_ack && !p_ack) begin nev++; ev = 3; end
      if (!link_ack && p_ack) begin nev++; ev = 4; end
      if (link_rdy && !p_rdy) begin nev++; ev = 5; end
      if (!link_rdy && p_rdy) begin nev++; ev = 6; end
      if (nev > 1) chk(0, "R3 simultaneous edges", nev, 1);
      else if (nev == 1) begin
        if (ev != exp_seq[step]) begin
          chk(0, "R3 edge order", ev, exp_seq[step]);
          step = 0;
        end else begin
          if (step == 3) ackfall_cyc = cyc;
          if (step == 4) chk((cyc - ackfall_cyc) == model_gap(exp_lat),
                             "R7 ready gap", cyc - ackfall_cyc, model_gap(exp_lat));
          step++;
          if (step == 8) begin
            chk(1, "R3 sequence", 8, 8);
            step = 0;
          end
        end
      end
      if (req_drive && rsp_drive) chk(0, "R8 two drivers", 2, 1);
      if (!req_drive && !rsp_drive && link_bus != '0)
        chk(0, "R8 idle lines", int'(link_bus), 0);
      if (link_req && (!req_drive || int'(link_bus) != cur_addr))
        chk(0, "R4 address on lines", int'(link_bus), cur_addr);
      if (link_rdy && (!rsp_drive || link_bus != model_word(cur_addr)))
        chk(0, "R5 word on lines", int'(link_bus), int'(model_word(cur_addr)));
    end
    p_req = link_req; p_ack = link_ack; p_rdy = link_rdy;
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!link_req && !link_ack && !link_rdy, "R1 control wires in reset",
        {link_req, link_ack, link_rdy}, 0);
    chk(!req_drive && !rsp_drive && link_bus == '0, "R1 lines in reset",
        int'(link_bus), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !link_req, "R1 state after reset", {busy, done, link_req}, 0);
  endtask

  task automatic t_read(input int a, input int l);
    bit seen;
    cur_addr = a; exp_lat = l;
    lat_cfg = LW'(l); addr = AW'(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && link_req && int'(link_bus) == a, "R2 launch", int'(link_bus), a);
    wait_done(seen);
    chk(seen, "R10 done seen", seen, 1);
    chk(rdata == model_word(a), "R6 returned word", int'(rdata), int'(model_word(a)));
    chk(!busy, "R10 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  task automatic t_latency_sweep();
    for (int l = 0; l < 16; l++) t_read((l * 7 + 3) % 16, l);
  endtask

  task automatic t_hold();
    logic [DW-1:0] keep;
    t_read(15, 0);
    keep = rdata;
    addr = 4'd2;
    repeat (20) @(negedge clk);
    chk(rdata == keep, "R6 word held", int'(rdata), int'(keep));
  endtask

  task automatic t_ignore_busy();
    bit seen;
    bit extra;
    cur_addr = 5; exp_lat = 3;
    lat_cfg = 4'd3; addr = 4'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    addr = 4'd10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk(seen && rdata == model_word(5), "R9 first address served",
        int'(rdata), int'(model_word(5)));
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done || busy || link_req) extra = 1;
    end
    chk(!extra, "R9 no second transaction", extra, 0);
  endtask

  task automatic t_back_to_back();
    t_read(0, 2);
    t_read(9, 1);
    t_read(6, 15);
  endtask

  initial begin
    t_reset();
    t_read(0, 0);
    t_read(15, 15);
    t_latency_sweep();
    t_hold();
    t_ignore_busy();
    t_back_to_back();
    repeat (5) @(negedge clk);
    chk(step == 0, "R3 no partial sequence left", step, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", step, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule